// File: doc/BRIEF.md
# Legacy Interrupt Status and Enable Register

This unit gathers four level-sensitive legacy interrupt lines (A, B, C and D) into one 32-bit control word. The same word holds a per-line enable field and a set of plain configuration fields. A host reads the word to see which lines are pending. It acknowledges a line by writing a one into that line's status bit. It changes the enable bits with ordinary byte-strobed writes. One registered interrupt output tells a parent interrupt controller that at least one enabled line is pending.

Status bits are write-one-to-clear, and the enable bits live in the same word. A host that changes enables by read-modify-write must therefore write zeros into the status field, or it will acknowledge lines it never meant to touch. A single halfword write of 0xF000 to the upper half clears every status bit and disables every line in one access. The other fields share the word: error-source enables, request-line priorities and a ready-wait count. They are stored and read back only.

Top module: `intx_ctl_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the read word is 0x00000000 and `irq_out` is 0.
- R2: Bit 28+i is the status of line i (line A at bit 28, line D at bit 31). It is set at the first clock edge that samples `line_in[i]` high. It then stays set after the line falls, until it is acknowledged.
- R3: A write with `reg_be[3]` high and bit 28+i of the data set clears status bit i at that edge. A zero in that data bit, a low `reg_be[3]` or a low `reg_wr` leaves the status bit unchanged.
- R4: If line i is still high when it is acknowledged, its status bit reads 0 for exactly one cycle and is set again at the next edge.
- R5: Bits 25:22 are the enables for lines D down to A (line A at bit 22). They are read/write through byte strobes, and a set bit lets its line interrupt.
- R6: `irq_out` is a registered signal. It equals the OR over all lines of (status AND enable), taken from the read word of the previous cycle.
- R7: Bits 27:26, 21:16, 14:8 and 3:0 are plain read/write storage. Each byte lane updates only when `reg_wr` and that lane's strobe are both high.
- R8: Bit 15 and bits 7:4 always read as zero, whatever is written to them.
- R9: A write of 0xF000 to the upper halfword (strobes 4'b1100) clears all four status bits and all four enables in the same edge. `irq_out` is low one cycle later if no line is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_be | input | 4 | Byte lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current value of the control word |
| line_in | input | 4 | Level interrupt lines, bit 0 is line A |
| irq_out | output | 1 | Combined interrupt to the parent controller |

## Verification
The main sweep raises each of the four lines in turn under all sixteen enable patterns. It checks both the status field and the combined output. This separates a bit-position slip in status or enable from a fault in the OR/AND merge. Acknowledges are tried with the line low, where the bit must stay clear, and with the line still high, where it must return after one cycle. Those two cases separate sticky capture from simple tracking of the line. Each byte lane is written on its own with several data patterns. The result is compared with a lane-by-lane model of writable bits, which shows up strobe decoding faults, leakage into neighbouring lanes and reserved bits that store data.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int REG_W    = 32;
  localparam int NLINE    = 4;
  localparam int STAT_LSB = 28;
  localparam int EN_LSB   = 22;
  localparam int LANES    = REG_W / 8;
  // bits that hold plain storage; status and reserved bits are excluded
  localparam logic [REG_W-1:0] CFG_RW_MASK = 32'h0FFF_7F0F;
endpackage

// File: rtl/intx_status_bank.sv
module intx_status_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] ack,
  output logic [N-1:0] status
);
  logic [N-1:0] status_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // acknowledge wins for one edge; a high line sets the bit again next edge
    always_comb begin
      if (ack[i]) status_d[i] = 1'b0;
      else        status_d[i] = status[i] | line_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= status_d[i];
    end
  end
endmodule

// File: rtl/intx_cfg_store.sv
module intx_cfg_store #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   q
);
  localparam int NL = W / 8;

  logic [W-1:0]  q_d;
  logic [NL-1:0] lane_en;

  for (genvar b = 0; b < NL; b++) begin : g_lane
    assign lane_en[b] = wr & be[b];

    always_comb begin
      q_d[b*8 +: 8] = wdata[b*8 +: 8] & MASK[b*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q[b*8 +: 8] <= 8'h00;
      else if (lane_en[b])   q[b*8 +: 8] <= q_d[b*8 +: 8];
    end
  end
endmodule

// File: rtl/intx_irq_merge.sv
module intx_irq_merge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status,
  input  logic [N-1:0] enable,
  output logic         irq_out
);
  logic irq_d;

  always_comb begin
    irq_d = |(status & enable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= irq_d;
  end
endmodule

// File: rtl/intx_ctl_unit.sv
module intx_ctl_unit
  import intx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [LANES-1:0] reg_be,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NLINE-1:0] line_in,
  output logic             irq_out
);
  localparam int STAT_LANE = STAT_LSB / 8;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [NLINE-1:0] ack;
  logic [NLINE-1:0] status;
  logic [REG_W-1:0] cfg_q;
  logic [NLINE-1:0] enable;

  always_comb begin
    if (reg_wr && reg_be[STAT_LANE]) ack = reg_wdata[STAT_LSB +: NLINE];
    else                             ack = '0;
  end

  intx_status_bank #(.N(NLINE)) u_status (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .line_in (line_in),
    .ack     (ack),
    .status  (status)
  );

  intx_cfg_store #(.W(REG_W), .MASK(CFG_RW_MASK)) u_cfg (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr    (reg_wr),
    .be    (reg_be),
    .wdata (reg_wdata),
    .q     (cfg_q)
  );

  assign enable = cfg_q[EN_LSB +: NLINE];

  intx_irq_merge #(.N(NLINE)) u_merge (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .status  (status),
    .enable  (enable),
    .irq_out (irq_out)
  );

  always_comb begin
    reg_rdata = cfg_q;
    reg_rdata[STAT_LSB +: NLINE] = status;
  end
endmodule

// File: rtl/intx_ctl_unit_chk.sv
module intx_ctl_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [3:0]  line_in,
  input logic        irq_out
);
  logic [3:0] ackv;
  assign ackv = (reg_wr && reg_be[3]) ? reg_wdata[31:28] : 4'h0;

  for (genvar i = 0; i < 4; i++) begin : g_line
    // R2: a sampled high line sets its status bit
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
      line_in[i] && !ackv[i] |=> reg_rdata[28+i]);
    // R2: status holds until acknowledged
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[28+i] && !ackv[i] |=> reg_rdata[28+i]);
    // R3: acknowledge clears the bit at that edge
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ackv[i] |=> !reg_rdata[28+i]);
  end

  // R6: registered merge of pending and enabled lines
  a_r6_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr || !reg_wr |=> irq_out == $past(|(reg_rdata[31:28] & reg_rdata[25:22])));

  // R7: lane 0 holds without its strobe
  a_r7_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_be[0]) |=> $stable(reg_rdata[3:0]));
endmodule

bind intx_ctl_unit intx_ctl_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .reg_wr    (reg_wr),
  .reg_be    (reg_be),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .line_in   (line_in),
  .irq_out   (irq_out)
);

// File: tb/intx_ctl_unit_tb.sv
module intx_ctl_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RW_MASK = 32'h0FFF_7F0F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  line_in;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intx_ctl_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .line_in   (line_in),
    .irq_out   (irq_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] be, logic [31:0] d);
    reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_be = 4'h0; reg_wdata = 32'h0;
  endtask

  task automatic clear_all();
    line_in = 4'h0;
    wr(4'b1100, 32'hF000_0000);
    step();
  endtask

  logic [31:0] model;

  initial begin
    reg_wr = 0; reg_be = 0; reg_wdata = 0; line_in = 4'hF;
    rst_n = 1'b0;
    repeat (3) step();
    // R1: reset state with lines high
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 irq", {31'h0, irq_out}, 32'h0);
    line_in = 4'h0;
    rst_n = 1'b1;
    repeat (3) step();
    check("R1 after release", reg_rdata, 32'h0);

    // R2/R5/R6: each line under every enable pattern
    for (int en = 0; en < 16; en++) begin
      for (int i = 0; i < 4; i++) begin
        clear_all();
        wr(4'b1100, 32'(en) << 22);
        check("R5 enable field", reg_rdata, 32'(en) << 22);
        line_in = 4'(1 << i);
        step();
        check("R2 status set", {28'h0, reg_rdata[31:28]}, 32'(1 << i));
        line_in = 4'h0;
        step();
        check("R6 irq", {31'h0, irq_out}, {31'h0, en[i]});
        check("R2 sticky", {28'h0, reg_rdata[31:28]}, 32'(1 << i));
        // R3: zero in status bit leaves it
        wr(4'b1000, 32'h0);
        check("R3 zero keeps", {28'h0, reg_rdata[31:28]}, 32'(1 << i));
        // R3: one with lane strobe off leaves it
        wr(4'b0111, 32'hF000_0000);
        check("R3 no strobe keeps", {28'h0, reg_rdata[31:28]}, 32'(1 << i));
        // R3: one with strobe clears
        wr(4'b1000, 32'hF000_0000);
        check("R3 ack clears", {28'h0, reg_rdata[31:28]}, 32'h0);
        step();
        check("R6 irq drops", {31'h0, irq_out}, 32'h0);
      end
    end

    // R4: acknowledge while line still high
    for (int i = 0; i < 4; i++) begin
      clear_all();
      line_in = 4'(1 << i);
      step();
      wr(4'b1000, 32'(1 << (28 + i)));
      check("R4 cleared one cycle", {28'h0, reg_rdata[31:28]}, 32'h0);
      step();
      check("R4 set again", {28'h0, reg_rdata[31:28]}, 32'(1 << i));
    end

    // R3: reg_wr low does nothing
    clear_all();
    line_in = 4'h3; step(); line_in = 4'h0;
    reg_wr = 1'b0; reg_be = 4'hF; reg_wdata = 32'hFFFF_FFFF;
    step();
    reg_be = 4'h0; reg_wdata = 32'h0;
    check("R3 no write strobe", reg_rdata, 32'h3000_0000);

    // R9: one halfword write clears status and enables
    wr(4'b1100, 32'h03C0_0000);
    line_in = 4'hF; step(); line_in = 4'h0; step();
    check("R9 preset", reg_rdata, 32'hF3C0_0000);
    check("R9 irq high", {31'h0, irq_out}, 32'h1);
    wr(4'b1100, 32'hF000_0000);
    check("R9 cleared", reg_rdata, 32'h0);
    step();
    check("R9 irq low", {31'h0, irq_out}, 32'h0);

    // R7/R8: byte lanes written alone
    clear_all();
    model = 32'h0;
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'hFF : (p == 1) ? 8'hA5 : (p == 2) ? 8'h5A : 8'h3C;
        wr(4'(1 << b), {4{pat}});
        model[b*8 +: 8] = pat & RW_MASK[b*8 +: 8];
        check("R7 lane write", reg_rdata, model);
        check("R8 reserved zero", {16'h0, reg_rdata[15], 3'h0, reg_rdata[7:4], 8'h0}, 32'h0);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule